// File: doc/BRIEF.md
# Double-Buffered Real-Time Clock Register Window

This block is a byte-wide, chip-select style slave that answers at the top eight addresses of an 8K-byte space. Behind those eight addresses it keeps a user copy of the calendar fields. The calendar counters themselves are external: they present their live values on `live_bcd`, and they pulse `sec_tick` once per second. Outside a halt, the user copy follows the counters on every tick. Two bits of the control byte change that. The read-halt bit freezes the copy so that software can read a coherent set of fields while counting goes on underneath. The write-halt bit also freezes the copy so that software can edit the fields. Clearing the write-halt bit hands the edited values to the counters through a single-cycle load strobe.

Register index (address bits 2:0): 0 control (bit 7 write-halt, bit 6 read-halt, bits 5:0 spare), 1 seconds (bit 7 oscillator stop, bits 6:0 value), 2 minutes (bits 6:0), 3 hours (bits 5:0), 4 weekday (bit 6 frequency test, bits 2:0 value), 5 day of month (bits 5:0), 6 month (bits 4:0), 7 year (bits 7:0). `live_bcd` and `load_bcd` pack registers 1 to 7 as bytes 0 to 6. Every bit that is neither a value bit nor a named control bit is spare storage.

A halt controller has five named states. RUN: the copy follows the ticks. RD_HALT: the copy is frozen for reading. WR_HALT: the copy is frozen for editing. COMMIT: a one-cycle state that pulses `load_en`. REFRESH: a one-cycle state that reloads the copy from the counters. The transitions are as follows. A control write with bit 7 set enters WR_HALT from RUN, RD_HALT, COMMIT or REFRESH. A control write with bit 6 set and bit 7 clear enters RD_HALT from RUN, COMMIT or REFRESH. A control write in RD_HALT with both bits clear enters REFRESH. A control write in WR_HALT with bit 7 clear enters COMMIT. From COMMIT the controller goes to RD_HALT if the stored read-halt bit is set, and to RUN otherwise. From REFRESH it goes to RUN.

Top module: `rtc_shadow_regs`

## Requirements
- R1: An access is taken only when `ce_n`=0, `ce2`=1, `pwr_fail`=0 and all address bits above bit 2 are 1. `we_n`=1 makes it a read, and `rvalid` with `rdata` follow one cycle later. Any other cycle leaves `rvalid` at 0.
- R2: Register indices and value masks are those listed above: seconds 0x7F, minutes 0x7F, hours 0x3F, weekday 0x07, day 0x3F, month 0x1F, year 0xFF.
- R3: In RUN, a `sec_tick` replaces the value bits of registers 1 to 7 with the matching bits of `live_bcd`.
- R4: After a control write with bit 6=1 and bit 7=0, ticks leave the copy unchanged.
- R5: A control write that clears both bits while in RD_HALT reloads every value field from `live_bcd` in the following cycle.
- R6: While bit 7 is set, the copy holds the written bytes. The control write that clears bit 7 raises `load_en` for exactly the next cycle, with `load_bcd` carrying the value bits of registers 1 to 7.
- R7: `osc_stop` equals seconds bit 7 and changes only through a write to index 1.
- R8: With weekday bit 6=1 and seconds bit 7=0, seconds bit 0 reads as a phase that starts at 0 and toggles on each `ft_tick`. Otherwise it reads as stored.
- R9: Spare bits, the two control bits of registers 1 and 4, and control bits 5:0 keep written data through every refresh.
- R10: While `pwr_fail`=1, writes have no effect and reads give `rvalid`=0.
- R11: After reset, seconds reads 0x80, all other registers read 0x00, the state is RUN, and `load_en` is 0.
- R12: A control write with bits 7 and 6 both set enters WR_HALT. When bit 7 is later cleared with bit 6 still set, the commit is followed by RD_HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_fail | input | 1 | Supply out of range; blocks all access |
| ce_n | input | 1 | Active-low select |
| ce2 | input | 1 | Active-high select |
| we_n | input | 1 | 0 = write, 1 = read |
| addr | input | ADDR_W (13) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after the read |
| rvalid | output | 1 | Read data valid |
| sec_tick | input | 1 | One-second update pulse from the counters |
| ft_tick | input | 1 | Pulse at twice the test-tone rate (toggles the phase) |
| live_bcd | input | 56 | Live counter fields, registers 1 to 7 |
| load_en | output | 1 | One-cycle strobe to load the counters |
| load_bcd | output | 56 | Value bits handed to the counters |
| osc_stop | output | 1 | Oscillator stop request |

## Verification
The checker watches several properties on every cycle. It confirms that a read is answered by `rvalid` one cycle later and that no `rvalid` appears without a read. It confirms that a power-fail cycle yields no data. It confirms that `load_en` is a lone pulse that appears only after a control write clearing bit 7, and that `osc_stop` moves only after a seconds write. The bench scenarios are needed for the behaviours that depend on values: whether a tick reaches the copy in each halt state, the exact refreshed and committed bytes, the survival of spare bits, and the phase pattern on seconds bit 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DW        = 8;
    localparam int REG_COUNT = 8;

    localparam int IX_CTRL  = 0;
    localparam int IX_SEC   = 1;
    localparam int IX_MIN   = 2;
    localparam int IX_HOUR  = 3;
    localparam int IX_WDAY  = 4;
    localparam int IX_MDAY  = 5;
    localparam int IX_MONTH = 6;
    localparam int IX_YEAR  = 7;

    localparam int WHALT_BIT = 7;
    localparam int RHALT_BIT = 6;
    localparam int OSC_BIT   = 7;
    localparam int FT_BIT    = 6;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_RD_HALT,
        ST_WR_HALT,
        ST_COMMIT,
        ST_REFRESH
    } rtc_state_e;

    // Bits of each register that belong to the live counters.
    function automatic logic [DW-1:0] time_mask(input int idx);
        case (idx)
            IX_SEC:   return 8'h7F;
            IX_MIN:   return 8'h7F;
            IX_HOUR:  return 8'h3F;
            IX_WDAY:  return 8'h07;
            IX_MDAY:  return 8'h3F;
            IX_MONTH: return 8'h1F;
            IX_YEAR:  return 8'hFF;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode #(
    parameter int ADDR_W = 13,
    parameter int IDX_W  = 3
) (
    input  logic              pwr_fail,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_wr,
    output logic              acc_rd,
    output logic [IDX_W-1:0]  acc_idx
);
    logic in_window;
    logic selected;

    always_comb begin
        in_window = &addr[ADDR_W-1:IDX_W];
        selected  = !pwr_fail && !ce_n && ce2 && in_window;
        acc_wr    = selected && !we_n;
        acc_rd    = selected && we_n;
        acc_idx   = addr[IDX_W-1:0];
    end
endmodule

// File: rtl/rtc_halt_fsm.sv
module rtc_halt_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_w,
    input  logic ctrl_r,
    input  logic held_r,
    input  logic sec_tick,
    output logic snap_en,
    output logic load_en
);
    rtc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ctrl_wr && ctrl_w)      state_d = ST_WR_HALT;
                else if (ctrl_wr && ctrl_r) state_d = ST_RD_HALT;
            end
            ST_RD_HALT: begin
                if (ctrl_wr && ctrl_w)       state_d = ST_WR_HALT;
                else if (ctrl_wr && !ctrl_r) state_d = ST_REFRESH;
            end
            ST_WR_HALT: begin
                if (ctrl_wr && !ctrl_w) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (ctrl_wr) state_d = ctrl_w ? ST_WR_HALT : (ctrl_r ? ST_RD_HALT : ST_RUN);
                else         state_d = held_r ? ST_RD_HALT : ST_RUN;
            end
            ST_REFRESH: begin
                if (ctrl_wr && ctrl_w)      state_d = ST_WR_HALT;
                else if (ctrl_wr && ctrl_r) state_d = ST_RD_HALT;
                else                        state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        snap_en = 1'b0;
        load_en = 1'b0;
        unique case (state_q)
            ST_RUN:     snap_en = sec_tick;
            ST_REFRESH: snap_en = 1'b1;
            ST_COMMIT:  load_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
    import rtc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_wr,
    input  logic                          acc_rd,
    input  logic [IDX_W-1:0]              acc_idx,
    input  logic [DW-1:0]                 wdata,
    input  logic                          snap_en,
    input  logic                          ft_tick,
    input  logic [(REG_COUNT-1)*DW-1:0]   live_bcd,
    output logic [DW-1:0]                 rdata,
    output logic                          rvalid,
    output logic                          held_r,
    output logic [(REG_COUNT-1)*DW-1:0]   load_bcd,
    output logic                          osc_stop
);
    logic [REG_COUNT*DW-1:0] regs_flat;
    logic [DW-1:0]           rd_byte;
    logic                    ft_on;
    logic                    ft_ph_q;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        localparam logic [DW-1:0] TMASK = time_mask(g);
        localparam logic [DW-1:0] RSTV  = (g == IX_SEC) ? DW'(1 << OSC_BIT) : '0;
        logic [DW-1:0] r_q;
        logic          hit;
        assign hit = acc_wr && (acc_idx == IDX_W'(g));

        if (g == IX_CTRL) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (!rst_n)   r_q <= RSTV;
                else if (hit) r_q <= wdata;
            end
        end else begin : g_time
            logic [DW-1:0] live_b;
            assign live_b = live_bcd[(g-1)*DW +: DW];
            always_ff @(posedge clk) begin
                if (!rst_n)       r_q <= RSTV;
                else if (hit)     r_q <= wdata;
                else if (snap_en) r_q <= (r_q & ~TMASK) | (live_b & TMASK);
            end
            assign load_bcd[(g-1)*DW +: DW] = r_q & TMASK;
        end

        assign regs_flat[g*DW +: DW] = r_q;
    end

    assign held_r   = regs_flat[IX_CTRL*DW + RHALT_BIT];
    assign osc_stop = regs_flat[IX_SEC*DW + OSC_BIT];
    assign ft_on    = regs_flat[IX_WDAY*DW + FT_BIT] && !osc_stop;

    always_ff @(posedge clk) begin
        if (!rst_n)     ft_ph_q <= 1'b0;
        else if (ft_on) ft_ph_q <= ft_ph_q ^ ft_tick;
        else            ft_ph_q <= 1'b0;
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (acc_idx == IDX_W'(i)) rd_byte = regs_flat[i*DW +: DW];
        end
        if (acc_idx == IDX_W'(IX_SEC) && ft_on) rd_byte[0] = ft_ph_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= acc_rd;
            rdata  <= acc_rd ? rd_byte : '0;
        end
    end
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pwr_fail,
    input  logic                        ce_n,
    input  logic                        ce2,
    input  logic                        we_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DW-1:0]               wdata,
    output logic [DW-1:0]               rdata,
    output logic                        rvalid,
    input  logic                        sec_tick,
    input  logic                        ft_tick,
    input  logic [(REG_COUNT-1)*DW-1:0] live_bcd,
    output logic                        load_en,
    output logic [(REG_COUNT-1)*DW-1:0] load_bcd,
    output logic                        osc_stop
);
    localparam int IDX_W = $clog2(REG_COUNT);

    logic             acc_wr, acc_rd, ctrl_wr, snap_en, held_r;
    logic [IDX_W-1:0] acc_idx;

    rtc_bus_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .pwr_fail(pwr_fail), .ce_n(ce_n), .ce2(ce2), .we_n(we_n), .addr(addr),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_idx(acc_idx)
    );

    assign ctrl_wr = acc_wr && (acc_idx == IDX_W'(IX_CTRL));

    rtc_halt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .ctrl_w(wdata[WHALT_BIT]), .ctrl_r(wdata[RHALT_BIT]), .held_r(held_r),
        .sec_tick(sec_tick), .snap_en(snap_en), .load_en(load_en)
    );

    rtc_user_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_idx(acc_idx),
        .wdata(wdata), .snap_en(snap_en), .ft_tick(ft_tick), .live_bcd(live_bcd),
        .rdata(rdata), .rvalid(rvalid), .held_r(held_r), .load_bcd(load_bcd),
        .osc_stop(osc_stop)
    );
endmodule

// File: rtl/rtc_shadow_regs_chk.sv
module rtc_shadow_regs_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_fail,
    input logic              ce_n,
    input logic              ce2,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              rvalid,
    input logic              load_en,
    input logic              osc_stop
);
    logic sel;
    assign sel = !pwr_fail && !ce_n && ce2 && (&addr[ADDR_W-1:3]);

    // R1: a read is answered one cycle later
    a_r1_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we_n) |=> rvalid);

    // R1: no data without a read
    a_r1_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && we_n) |=> !rvalid);

    // R10: power fail blocks reads
    a_r10_pwrfail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !rvalid);

    // R6: the load strobe follows a control write that clears the write bit
    a_r6_load_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> $past(sel && !we_n && addr[2:0] == 3'd0 && !wdata[7]));

    // R6: the load strobe lasts one cycle
    a_r6_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !load_en);

    // R7: the oscillator stop output moves only after a seconds write
    a_r7_osc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !we_n && addr[2:0] == 3'd1) |=> $stable(osc_stop));
endmodule

bind rtc_shadow_regs rtc_shadow_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .ce_n(ce_n), .ce2(ce2),
    .we_n(we_n), .addr(addr), .wdata(wdata), .rvalid(rvalid),
    .load_en(load_en), .osc_stop(osc_stop)
);

// File: tb/rtc_shadow_regs_tb.sv
`timescale 1ns/1ps
module rtc_shadow_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_fail = 1'b0, ce_n = 1'b1, ce2 = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rvalid, load_en, osc_stop;
    logic        sec_tick = 1'b0, ft_tick = 1'b0;
    logic [55:0] live_bcd = '0;
    logic [55:0] load_bcd;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m [8];
    logic [7:0] live [8];
    int mode = 0;     // 0 run, 1 read halt, 2 write halt
    bit ph = 1'b0;

    always #2.5 clk = ~clk;

    rtc_shadow_regs u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .ce_n(ce_n), .ce2(ce2),
        .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .sec_tick(sec_tick), .ft_tick(ft_tick), .live_bcd(live_bcd),
        .load_en(load_en), .load_bcd(load_bcd), .osc_stop(osc_stop)
    );

    function automatic logic [7:0] vmask(input int i);
        case (i)
            1, 2: return 8'h7F;
            3, 5: return 8'h3F;
            4:    return 8'h07;
            6:    return 8'h1F;
            7:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit ft_on();
        return m[4][6] && !m[1][7];
    endfunction

    function automatic logic [7:0] rd_exp(input int i);
        logic [7:0] b = m[i];
        if (i == 1 && ft_on()) b[0] = ph;
        return b;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic refresh_model();
        for (int i = 1; i < 8; i++) m[i] = (m[i] & ~vmask(i)) | (live[i] & vmask(i));
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic bus_wr(input int idx, input logic [7:0] d, input bit pf = 0);
        bit pre_on = ft_on();
        ce_n = 0; ce2 = 1; we_n = 0; pwr_fail = pf;
        addr = {10'h3FF, 3'(idx)}; wdata = d;
        @(negedge clk);
        ce_n = 1; we_n = 1; pwr_fail = 0;
        if (!pf) begin
            m[idx] = d;
            if (!pre_on || !ft_on()) ph = 0;
            if (idx == 0) begin
                bit exp_ld = (mode == 2) && !d[7];
                bit rf = (mode == 1) && !d[7] && !d[6];
                check("R6 load_en", {63'd0, load_en}, {63'd0, exp_ld});
                if (exp_ld)
                    for (int i = 1; i < 8; i++)
                        check("R6 load_bcd", {56'd0, load_bcd[(i-1)*8 +: 8]}, {56'd0, m[i] & vmask(i)});
                mode = d[7] ? 2 : (d[6] ? 1 : 0);
                idle();
                if (rf) refresh_model();
            end
        end
    endtask

    // how: 0 normal, 1 power fail, 2 outside window, 3 ce2 low
    task automatic bus_rd(input int idx, input string tag, input int how = 0);
        logic [7:0] e = rd_exp(idx);
        ce_n = 0; ce2 = (how != 3); we_n = 1; pwr_fail = (how == 1);
        addr = (how == 2) ? {10'h1FE, 3'(idx)} : {10'h3FF, 3'(idx)};
        @(negedge clk);
        ce_n = 1; ce2 = 1; pwr_fail = 0;
        check({tag, " rvalid"}, {63'd0, rvalid}, {63'd0, (how == 0)});
        if (how == 0) check(tag, {56'd0, rdata}, {56'd0, e});
    endtask

    task automatic tick(input bit rnd = 1);
        if (rnd) for (int i = 1; i < 8; i++) live[i] = 8'($urandom);
        for (int i = 1; i < 8; i++) live_bcd[(i-1)*8 +: 8] = live[i];
        sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
        if (mode == 0) refresh_model();
    endtask

    task automatic ftick();
        ft_tick = 1;
        @(negedge clk);
        ft_tick = 0;
        if (ft_on()) ph = ~ph;
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 8; i++) bus_rd(i, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 8; i++) begin m[i] = 8'h00; live[i] = 8'h00; end
        m[1] = 8'h80;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        check("R11 load_en", {63'd0, load_en}, 64'd0);
        check("R11 rvalid", {63'd0, rvalid}, 64'd0);
        check("R7 osc_stop reset", {63'd0, osc_stop}, 64'd1);
        read_all("R11 reset value");
        // R7 start the oscillator
        bus_wr(1, 8'h00);
        idle();
        check("R7 osc_stop cleared", {63'd0, osc_stop}, 64'd0);
        // R9 spare bits in month, R2/R3 tick in run
        bus_wr(6, 8'hE0);
        live[1] = 8'h59; live[2] = 8'h34; live[3] = 8'h23; live[4] = 8'h05;
        live[5] = 8'h31; live[6] = 8'h12; live[7] = 8'h99;
        tick(0);
        read_all("R3 run refresh");
        check("R9 month spare", {56'd0, m[6]}, 64'hF2);
        // R4 read halt
        bus_wr(0, 8'h40);
        tick(); tick();
        read_all("R4 frozen");
        // R5 release
        bus_wr(0, 8'h00);
        read_all("R5 refreshed");
        // R6 write halt and commit
        bus_wr(0, 8'h80);
        bus_wr(2, 8'h45); bus_wr(3, 8'h17); bus_wr(7, 8'h24);
        tick();
        read_all("R6 held");
        bus_wr(0, 8'h00);
        tick();
        read_all("R3 after commit");
        // R12 both bits
        bus_wr(0, 8'hC0);
        bus_wr(5, 8'h09);
        bus_wr(0, 8'h40);
        check("R12 mode read halt", mode, 1);
        tick();
        read_all("R12 frozen after commit");
        bus_wr(0, 8'h00);
        read_all("R5 release after R12");
        // R8 frequency test
        bus_wr(4, 8'h43);
        for (int k = 0; k < 3; k++) begin ftick(); bus_rd(1, "R8 phase"); end
        bus_wr(1, 8'h81);
        ftick();
        bus_rd(1, "R8 stopped");
        bus_wr(1, 8'h00);
        bus_wr(4, 8'h02);
        // R10 power fail and R1 selection
        bus_wr(7, 8'h11, 1);
        bus_rd(7, "R10 write blocked");
        bus_rd(7, "R10 read blocked", 1);
        bus_rd(7, "R1 outside window", 2);
        bus_rd(7, "R1 ce2 low", 3);
        // random mix
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 9);
            int ix = $urandom_range(0, 7);
            case (op)
                0, 1, 2: begin
                    logic [7:0] d = 8'($urandom);
                    if (ix == 0 && $urandom_range(0, 1) == 1) d[5:0] = 6'd0;
                    bus_wr(ix, d);
                end
                3, 4, 5: bus_rd(ix, "R3/R9 random read");
                6, 7:    tick();
                8:       ftick();
                default: begin
                    bus_wr(ix, 8'($urandom), 1);
                    bus_rd(ix, "R10 random", $urandom_range(0, 3));
                end
            endcase
        end
        read_all("R2 final");
        report();
    end
endmodule